// File: doc/BRIEF.md
# Multi-Condition Capture Trigger Generator

This block decides when a logic-analyzer capture should start. It watches eighteen single-bit sources: sixteen data pins and two external trigger pins. For every source it can detect five conditions: a rising edge, a falling edge, a change in either direction, a low level and a high level. Each condition on each source has its own enable. The enabled conditions are merged into one logic trigger, either by OR (any enabled condition is enough) or by AND (every enabled condition must hold in the same sample).

A final selector passes either this logic trigger or a trigger coming from the analog capture path. The selected trigger then goes through a holdoff stage. A qualifying sample produces a one-cycle trigger pulse. It also loads a down-counter, and new trigger events are ignored while that counter runs. A sticky status flag records that a trigger has occurred. Software clears the flag by writing a one.

The inputs are taken as already synchronized to `clk`. Every control field arrives as a plain input, and each clock edge takes one sample.

Top module: `capture_trigger_gen`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `trigPulse`, `triggered` and `holdoffActive` are 0.
- R2: Source index i for i in 0..15 is `dataIn[i]`. Index 16 is `extTrigIn[0]` and index 17 is `extTrigIn[1]`. Bit i of every enable vector applies only to source i.
- R3: Edge conditions compare each source with its value at the previous clock edge. Rising means 0 then 1, falling means 1 then 0, and any-edge means the two values differ. The first sample after reset never counts as an edge.
- R4: The low-level condition holds when the source is 0 in the current sample. The high-level condition holds when it is 1.
- R5: With `combineAnd`=0, the logic trigger is true when at least one enabled condition holds.
- R6: With `combineAnd`=1, the logic trigger is true only when every enabled condition holds and at least one is enabled. With no enable set, no logic trigger is produced in either mode.
- R7: `sourceSel`=0 selects the logic trigger and `sourceSel`=1 selects `analogTrigIn`. The source that is not selected has no effect.
- R8: A qualifying sample taken at a clock edge raises `trigPulse` for exactly the following cycle.
- R9: A trigger taken at an edge loads the `holdoffCount` value presented at that edge. The next H samples are then ignored, and `holdoffActive` is 1 during exactly those H cycles.
- R10: With `holdoffCount`=0 there is no suppression, and each consecutive qualifying sample produces a pulse.
- R11: `triggered` goes to 1 together with `trigPulse` and stays 1 until it is cleared.
- R12: A cycle with `clrWr`=1 and `clrData`=1 clears `triggered`. With `clrData`=0 the write has no effect. A trigger in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 16 | Synchronized data pins (sources 0..15) |
| extTrigIn | input | 2 | Synchronized external trigger pins (sources 16, 17) |
| analogTrigIn | input | 1 | Trigger from the analog capture path |
| anyEdgeEn | input | 18 | Per-source enable for the any-edge condition |
| riseEdgeEn | input | 18 | Per-source enable for the rising-edge condition |
| fallEdgeEn | input | 18 | Per-source enable for the falling-edge condition |
| lowLevelEn | input | 18 | Per-source enable for the low-level condition |
| highLevelEn | input | 18 | Per-source enable for the high-level condition |
| combineAnd | input | 1 | 0: OR of enabled conditions, 1: AND |
| sourceSel | input | 1 | 0: logic trigger, 1: analog-path trigger |
| holdoffCount | input | 32 | Number of samples ignored after each trigger |
| clrWr | input | 1 | Status write strobe |
| clrData | input | 1 | Status write data; 1 clears the flag |
| trigPulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky trigger status |
| holdoffActive | output | 1 | High while the holdoff window runs |

## Verification
The assertions check the holdoff and status rules on every cycle. No pulse may follow a cycle inside the window. A pulse with a non-zero count must open the window, and a zero count must leave it closed. The flag may rise only together with a pulse. A one-write must clear the flag unless a trigger coincides with it, and any other cycle must keep the flag. The analog selection and the no-enable case must block pulses.

Other behaviours depend on input history and on the combination of enables, so only the bench's scenarios and its cycle-accurate reference model can show them. These are the polarity of each edge condition, the suppressed edge after reset, the source index mapping, and the exact AND/OR result over mixed enables.

// File: rtl/trig_gen_pkg.sv
package trig_gen_pkg;

  // condition slot order inside a per-source enable group
  localparam int COND_ANY  = 0;
  localparam int COND_RISE = 1;
  localparam int COND_FALL = 2;
  localparam int COND_LOW  = 3;
  localparam int COND_HIGH = 4;
  localparam int NUM_COND  = 5;

  typedef enum logic {
    SRC_LOGIC  = 1'b0,
    SRC_ANALOG = 1'b1
  } trigSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;      // qualified trigger this sample
    logic loadHold;  // reload holdoff counter
    logic decHold;   // count holdoff down
    logic clrFlag;   // one-write to status
  } trigStrobes_t;

endpackage

// File: rtl/trig_source_cond.sv
module trig_source_cond
  import trig_gen_pkg::*;
(
  input  logic                cur,
  input  logic                prev,
  input  logic                primed,
  input  logic [NUM_COND-1:0] condEn,
  output logic                hit,
  output logic                met,
  output logic                used
);

  logic [NUM_COND-1:0] condTrue;

  always_comb begin
    condTrue            = '0;
    condTrue[COND_ANY]  = primed & (cur ^ prev);
    condTrue[COND_RISE] = primed & cur & ~prev;
    condTrue[COND_FALL] = primed & ~cur & prev;
    condTrue[COND_LOW]  = ~cur;
    condTrue[COND_HIGH] = cur;
  end

  assign hit  = |(condEn & condTrue);
  assign met  = &(~condEn | condTrue);
  assign used = |condEn;

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_gen_pkg::*;
#(
  parameter int NUM_SRC = 18,
  parameter int HOLD_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] anyEn,
  input  logic [NUM_SRC-1:0] riseEn,
  input  logic [NUM_SRC-1:0] fallEn,
  input  logic [NUM_SRC-1:0] lowEn,
  input  logic [NUM_SRC-1:0] highEn,
  input  logic               combineAnd,
  input  trigStrobes_t       strobes,
  input  logic [HOLD_W-1:0]  holdoffCount,
  output logic               logicTrig,
  output logic               holdZero,
  output logic               trigPulse,
  output logic               triggered,
  output logic               holdoffActive
);

  logic [NUM_SRC-1:0] prevSrc;
  logic               primed;
  logic [NUM_SRC-1:0] hitVec;
  logic [NUM_SRC-1:0] metVec;
  logic [NUM_SRC-1:0] usedVec;
  logic [HOLD_W-1:0]  holdCnt;
  logic               orTrig;
  logic               andTrig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [NUM_COND-1:0] condEn;
    always_comb begin
      condEn            = '0;
      condEn[COND_ANY]  = anyEn[i];
      condEn[COND_RISE] = riseEn[i];
      condEn[COND_FALL] = fallEn[i];
      condEn[COND_LOW]  = lowEn[i];
      condEn[COND_HIGH] = highEn[i];
    end
    trig_source_cond u_cond (
      .cur    (srcIn[i]),
      .prev   (prevSrc[i]),
      .primed (primed),
      .condEn (condEn),
      .hit    (hitVec[i]),
      .met    (metVec[i]),
      .used   (usedVec[i])
    );
  end

  assign orTrig    = |hitVec;
  assign andTrig   = (&metVec) & (|usedVec);
  assign logicTrig = combineAnd ? andTrig : orTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSrc   <= '0;
      primed    <= 1'b0;
      holdCnt   <= '0;
      trigPulse <= 1'b0;
      triggered <= 1'b0;
    end else begin
      prevSrc   <= srcIn;
      primed    <= 1'b1;
      trigPulse <= strobes.fire;
      triggered <= strobes.fire | (triggered & ~strobes.clrFlag);
      if (strobes.loadHold) begin
        holdCnt <= holdoffCount;
      end else if (strobes.decHold) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  assign holdZero      = (holdCnt == '0);
  assign holdoffActive = ~holdZero;

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_gen_pkg::*;
(
  input  logic         logicTrig,
  input  logic         analogTrigIn,
  input  logic         sourceSel,
  input  logic         holdZero,
  input  logic         clrWr,
  input  logic         clrData,
  output trigStrobes_t strobes
);

  trigSrc_t srcSel;
  logic     selTrig;

  assign srcSel = trigSrc_t'(sourceSel);

  always_comb begin
    unique case (srcSel)
      SRC_ANALOG: selTrig = analogTrigIn;
      default:    selTrig = logicTrig;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.fire     = selTrig & holdZero;
    strobes.loadHold = selTrig & holdZero;
    strobes.decHold  = ~holdZero;
    strobes.clrFlag  = clrWr & clrData;
  end

endmodule

// File: rtl/capture_trigger_gen.sv
module capture_trigger_gen
  import trig_gen_pkg::*;
#(
  parameter int NUM_DATA = 16,
  parameter int NUM_EXT  = 2,
  parameter int HOLD_W   = 32,
  localparam int NUM_SRC = NUM_DATA + NUM_EXT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_DATA-1:0] dataIn,
  input  logic [NUM_EXT-1:0]  extTrigIn,
  input  logic                analogTrigIn,
  input  logic [NUM_SRC-1:0]  anyEdgeEn,
  input  logic [NUM_SRC-1:0]  riseEdgeEn,
  input  logic [NUM_SRC-1:0]  fallEdgeEn,
  input  logic [NUM_SRC-1:0]  lowLevelEn,
  input  logic [NUM_SRC-1:0]  highLevelEn,
  input  logic                combineAnd,
  input  logic                sourceSel,
  input  logic [HOLD_W-1:0]   holdoffCount,
  input  logic                clrWr,
  input  logic                clrData,
  output logic                trigPulse,
  output logic                triggered,
  output logic                holdoffActive
);

  trigStrobes_t strobes;
  logic         logicTrig;
  logic         holdZero;

  trig_datapath #(
    .NUM_SRC (NUM_SRC),
    .HOLD_W  (HOLD_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .srcIn         ({extTrigIn, dataIn}),
    .anyEn         (anyEdgeEn),
    .riseEn        (riseEdgeEn),
    .fallEn        (fallEdgeEn),
    .lowEn         (lowLevelEn),
    .highEn        (highLevelEn),
    .combineAnd    (combineAnd),
    .strobes       (strobes),
    .holdoffCount  (holdoffCount),
    .logicTrig     (logicTrig),
    .holdZero      (holdZero),
    .trigPulse     (trigPulse),
    .triggered     (triggered),
    .holdoffActive (holdoffActive)
  );

  trig_ctrl u_ctrl (
    .logicTrig    (logicTrig),
    .analogTrigIn (analogTrigIn),
    .sourceSel    (sourceSel),
    .holdZero     (holdZero),
    .clrWr        (clrWr),
    .clrData      (clrData),
    .strobes      (strobes)
  );

endmodule

// File: rtl/trig_gen_checker.sv
module trig_gen_checker #(
  parameter int NUM_SRC = 18,
  parameter int HOLD_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               analogTrigIn,
  input logic [NUM_SRC-1:0] anyEdgeEn,
  input logic [NUM_SRC-1:0] riseEdgeEn,
  input logic [NUM_SRC-1:0] fallEdgeEn,
  input logic [NUM_SRC-1:0] lowLevelEn,
  input logic [NUM_SRC-1:0] highLevelEn,
  input logic               sourceSel,
  input logic [HOLD_W-1:0]  holdoffCount,
  input logic               clrWr,
  input logic               clrData,
  input logic               trigPulse,
  input logic               triggered,
  input logic               holdoffActive
);

  logic noEnable;
  assign noEnable = ~|(anyEdgeEn | riseEdgeEn | fallEdgeEn | lowLevelEn | highLevelEn);

  assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    holdoffActive |=> !trigPulse);

  assert_hold_opens_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && ($past(holdoffCount) != '0)) |-> holdoffActive);

  assert_zero_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && ($past(holdoffCount) == '0)) |-> !holdoffActive);

  assert_pulse_sets_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> triggered);

  assert_flag_rise_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(triggered) |-> trigPulse);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && clrData) |=> (!triggered || trigPulse));

  assert_flag_kept_R12: assert property (@(posedge clk) disable iff (!rstN)
    (triggered && !(clrWr && clrData)) |=> triggered);

  assert_analog_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sourceSel && !analogTrigIn) |=> !trigPulse);

  assert_no_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!sourceSel && noEnable) |=> !trigPulse);

endmodule

bind capture_trigger_gen trig_gen_checker #(
  .NUM_SRC (NUM_SRC),
  .HOLD_W  (HOLD_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .analogTrigIn  (analogTrigIn),
  .anyEdgeEn     (anyEdgeEn),
  .riseEdgeEn    (riseEdgeEn),
  .fallEdgeEn    (fallEdgeEn),
  .lowLevelEn    (lowLevelEn),
  .highLevelEn   (highLevelEn),
  .sourceSel     (sourceSel),
  .holdoffCount  (holdoffCount),
  .clrWr         (clrWr),
  .clrData       (clrData),
  .trigPulse     (trigPulse),
  .triggered     (triggered),
  .holdoffActive (holdoffActive)
);

// File: tb/capture_trigger_gen_bench.sv
`timescale 1ns/1ps
module capture_trigger_gen_bench;

  localparam int CYCLE_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] dataIn;
  logic [1:0]  extTrigIn;
  logic        analogTrigIn;
  logic [17:0] anyEdgeEn, riseEdgeEn, fallEdgeEn, lowLevelEn, highLevelEn;
  logic        combineAnd, sourceSel;
  logic [31:0] holdoffCount;
  logic        clrWr, clrData;
  logic        trigPulse, triggered, holdoffActive;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  bit          mPrev[18];
  bit          mPrimed;
  longint      mHold;
  bit          mPulse;
  bit          mTrig;

  always #2.5 clk = ~clk;

  capture_trigger_gen u_capture_trigger_gen (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .extTrigIn(extTrigIn),
    .analogTrigIn(analogTrigIn), .anyEdgeEn(anyEdgeEn), .riseEdgeEn(riseEdgeEn),
    .fallEdgeEn(fallEdgeEn), .lowLevelEn(lowLevelEn), .highLevelEn(highLevelEn),
    .combineAnd(combineAnd), .sourceSel(sourceSel), .holdoffCount(holdoffCount),
    .clrWr(clrWr), .clrData(clrData), .trigPulse(trigPulse),
    .triggered(triggered), .holdoffActive(holdoffActive)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit srcBit(int i);
    if (i < 16) return dataIn[i];
    return extTrigIn[i-16];
  endfunction

  function automatic bit modelLogic();
    int enabled = 0;
    int holding = 0;
    for (int i = 0; i < 18; i++) begin
      bit cur = srcBit(i);
      bit p = mPrev[i];
      bit en[5];
      bit ok[5];
      en[0] = anyEdgeEn[i];   ok[0] = mPrimed && (cur != p);
      en[1] = riseEdgeEn[i];  ok[1] = mPrimed && cur && !p;
      en[2] = fallEdgeEn[i];  ok[2] = mPrimed && !cur && p;
      en[3] = lowLevelEn[i];  ok[3] = !cur;
      en[4] = highLevelEn[i]; ok[4] = cur;
      for (int c = 0; c < 5; c++) begin
        if (en[c]) begin
          enabled++;
          if (ok[c]) holding++;
        end
      end
    end
    if (enabled == 0) return 0;
    if (combineAnd) return holding == enabled;
    return holding > 0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 18; i++) mPrev[i] = 0;
    mPrimed = 0; mHold = 0; mPulse = 0; mTrig = 0;
  endtask

  // one clock: model steps at the edge, outputs compared at the falling edge
  task automatic cycle(string tag);
    @(posedge clk);
    if (!rstN) begin
      modelReset();
    end else begin
      bit sel = sourceSel ? analogTrigIn : modelLogic();
      bit fire = sel && (mHold == 0);
      mPulse = fire;
      if (fire) mHold = longint'(holdoffCount);
      else if (mHold > 0) mHold--;
      mTrig = fire || (mTrig && !(clrWr && clrData));
      for (int i = 0; i < 18; i++) mPrev[i] = srcBit(i);
      mPrimed = 1;
    end
    @(negedge clk);
    chk(tag, "trigPulse", trigPulse, mPulse);
    chk(tag, "triggered", triggered, mTrig);
    chk(tag, "holdoffActive", holdoffActive, mHold != 0);
  endtask

  task automatic clearAll();
    anyEdgeEn = '0; riseEdgeEn = '0; fallEdgeEn = '0; lowLevelEn = '0; highLevelEn = '0;
    combineAnd = 0; sourceSel = 0; analogTrigIn = 0; clrWr = 0; clrData = 0;
  endtask

  task automatic applyReset();
    rstN = 0;
    cycle("R1"); cycle("R1");
    rstN = 1;
  endtask

  task automatic writeClear(string tag, bit d);
    clrWr = 1; clrData = d;
    cycle(tag);
    clrWr = 0; clrData = 0;
  endtask

  initial begin
    #(CYCLE_LIMIT * 5.0);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    void'($urandom(seed));
    dataIn = '0; extTrigIn = '0; holdoffCount = '0;
    clearAll();
    modelReset();
    rstN = 0;
    @(negedge clk);
    chk("R1", "trigPulse in reset", trigPulse, 1'b0);
    chk("R1", "triggered in reset", triggered, 1'b0);
    chk("R1", "holdoffActive in reset", holdoffActive, 1'b0);
    applyReset();
    cycle("R1");
    chk("R1", "pulse after release", trigPulse, 1'b0);

    // R4 / R10: high level on data pin 5, no holdoff
    highLevelEn[5] = 1;
    dataIn[5] = 1;
    repeat (3) cycle("R10");
    chk("R10", "pulse on third held sample", trigPulse, 1'b1);
    dataIn[5] = 0;
    cycle("R4");
    chk("R4", "no pulse when pin low", trigPulse, 1'b0);
    highLevelEn = '0;

    // R12: zero write keeps flag, one write clears it
    writeClear("R12", 0);
    chk("R12", "flag after zero write", triggered, 1'b1);
    writeClear("R12", 1);
    chk("R12", "flag after one write", triggered, 1'b0);

    // R4 low level on external pin 0 (source 16)
    lowLevelEn[16] = 1;
    cycle("R4"); cycle("R4");
    extTrigIn[0] = 1;
    cycle("R4");
    lowLevelEn = '0;
    writeClear("R12", 1);

    // R12: trigger and clear together leave flag set
    highLevelEn[2] = 1; dataIn[2] = 1;
    writeClear("R12", 1);
    chk("R12", "set wins over clear", triggered, 1'b1);
    highLevelEn = '0; dataIn[2] = 0;
    cycle("R12");
    writeClear("R12", 1);

    // R3: rising edge on source 17, falling on data 0, any edge on data 15
    riseEdgeEn[17] = 1;
    extTrigIn[1] = 1; cycle("R3");
    chk("R3", "rise on ext pin 1", trigPulse, 1'b1);
    cycle("R3");
    chk("R8", "pulse lasts one cycle", trigPulse, 1'b0);
    extTrigIn[1] = 0; cycle("R3");
    riseEdgeEn = '0;
    fallEdgeEn[0] = 1;
    dataIn[0] = 1; cycle("R3");
    dataIn[0] = 0; cycle("R3");
    chk("R3", "fall on data 0", trigPulse, 1'b1);
    fallEdgeEn = '0;
    anyEdgeEn[15] = 1;
    dataIn[15] = 1; cycle("R3");
    dataIn[15] = 0; cycle("R3");
    cycle("R3");
    anyEdgeEn = '0;

    // R2: enable on source 16 does not react to source 17
    riseEdgeEn[16] = 1;
    extTrigIn[1] = 1; cycle("R2");
    chk("R2", "wrong pin ignored", trigPulse, 1'b0);
    extTrigIn[1] = 0; dataIn = 16'hFFFF; cycle("R2");
    riseEdgeEn = '0; dataIn = '0;
    cycle("R2");

    // R3: no edge on first sample after reset
    riseEdgeEn[3] = 1; dataIn[3] = 1;
    applyReset();
    cycle("R3");
    chk("R3", "no edge after reset", trigPulse, 1'b0);
    cycle("R3");
    riseEdgeEn = '0; dataIn = '0;
    cycle("R3");

    // R5 OR mode with two enables, one true
    highLevelEn[7] = 1; highLevelEn[8] = 1; dataIn[8] = 1;
    cycle("R5");
    chk("R5", "or of two", trigPulse, 1'b1);
    clearAll(); dataIn = '0;

    // R6 AND mode
    combineAnd = 1;
    highLevelEn[3] = 1; riseEdgeEn[4] = 1;
    dataIn[3] = 1; cycle("R6");
    chk("R6", "and with one missing", trigPulse, 1'b0);
    dataIn[4] = 1; cycle("R6");
    chk("R6", "and all met", trigPulse, 1'b1);
    dataIn[3] = 0; dataIn[4] = 0; cycle("R6");
    dataIn[4] = 1; cycle("R6");
    chk("R6", "and with level false", trigPulse, 1'b0);
    highLevelEn = '0; riseEdgeEn = '0;
    for (int k = 0; k < 6; k++) begin
      dataIn = ~dataIn; extTrigIn = ~extTrigIn;
      cycle("R6");
      chk("R6", "no enable in and mode", trigPulse, 1'b0);
    end
    combineAnd = 0;
    cycle("R6");
    chk("R6", "no enable in or mode", trigPulse, 1'b0);
    dataIn = '0; extTrigIn = '0;

    // R7 source select
    highLevelEn[9] = 1; dataIn[9] = 1; sourceSel = 1;
    cycle("R7");
    chk("R7", "logic ignored when analog selected", trigPulse, 1'b0);
    analogTrigIn = 1; cycle("R7");
    chk("R7", "analog trigger", trigPulse, 1'b1);
    sourceSel = 0; dataIn[9] = 0; cycle("R7");
    chk("R7", "analog ignored when logic selected", trigPulse, 1'b0);
    clearAll(); dataIn = '0;

    // R9 holdoff of 4 with a held level
    holdoffCount = 4;
    highLevelEn[11] = 1; dataIn[11] = 1;
    cycle("R9");
    chk("R9", "first pulse", trigPulse, 1'b1);
    for (int k = 0; k < 4; k++) begin
      cycle("R9");
      chk("R9", "suppressed in window", trigPulse, 1'b0);
    end
    cycle("R9");
    chk("R9", "pulse after window", trigPulse, 1'b1);
    repeat (10) cycle("R9");
    clearAll(); dataIn = '0; holdoffCount = 0;
    cycle("R9");

    // mixed random phase against the model
    for (int blk = 0; blk < 40; blk++) begin
      anyEdgeEn   = 18'($urandom & $urandom & $urandom);
      riseEdgeEn  = 18'($urandom & $urandom & $urandom);
      fallEdgeEn  = 18'($urandom & $urandom & $urandom);
      lowLevelEn  = 18'($urandom & $urandom & $urandom & $urandom);
      highLevelEn = 18'($urandom & $urandom & $urandom & $urandom);
      combineAnd  = 1'($urandom);
      sourceSel   = (($urandom % 5) == 0);
      holdoffCount = $urandom % 8;
      for (int k = 0; k < 20; k++) begin
        dataIn = 16'($urandom); extTrigIn = 2'($urandom);
        analogTrigIn = 1'($urandom);
        clrWr = (($urandom % 4) == 0); clrData = 1'($urandom);
        cycle(combineAnd ? "R6" : "R5");
      end
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule